// File: doc/BRIEF.md
# Dual-Law Companding Converter

This block converts between signed linear audio samples and 8-bit companded telephony codes in both directions at once. An encoder path takes a valid-qualified two's-complement sample and returns the 8-bit code. A decoder path takes a valid-qualified 8-bit code and returns the reconstructed linear sample. One select input picks the companding law for both paths: µ-law or A-law. Both laws follow the standard eight-segment, sixteen-step structure, including the bit inversions applied to the line code.

Each path has one register stage. A result appears one clock after its valid input, together with a registered valid flag. When the valid input is low, the data register keeps its last value. The linear width is a parameter `LIN_W` of at least 16. The encoder uses the top 14 bits of the sample for µ-law and the top 13 bits for A-law. The decoder produces a 16-bit-scale value, left-aligned in `LIN_W` bits.

Top module: `g711_compander`

## Requirements
- R1: While `rst_ni` is low, and at the first sample after reset before any valid input, `enc_valid_o` and `dec_valid_o` are 0, `enc_code_o` is 8'h00 and `dec_lin_o` is 0.
- R2: `enc_valid_o` and `dec_valid_o` equal the matching valid input of the previous clock cycle.
- R3: When a valid input is low, the data output of that path keeps its previous value in the next cycle.
- R4: In both laws, code bit 7 is 1 for a non-negative linear input and 0 for a negative one.
- R5: µ-law encoding (select = 0) works as follows. Take the top 14 bits as signed value v and its magnitude m, with m limited to 8159. Add 33 to m. The segment s (0..7) is the position of the leading one minus 5. The step is the 4 bits just below that leading one. The code is {sign, s, step}, where sign is 1 for negative, and the whole byte is inverted.
- R6: In µ-law, the encoder clamps magnitudes above 8159 (on the 14-bit scale) to full scale. Positive full scale gives 8'h80, negative full scale gives 8'h00 and an input of 0 gives 8'hFF.
- R7: A-law encoding (select = 1) takes the top 13 bits as signed value v. The magnitude is m = v for v >= 0 and m = -v-1 otherwise. Segment 0 covers m < 32 with a step size of 2. Segment s >= 1 covers m in [16·2^s, 32·2^s) with step bits m[s+3:s]. The natural code is {v >= 0, s, step}, with bits 6,4,2,0 (8'h55) then inverted.
- R8: In A-law, positive full scale gives 8'hAA, negative full scale gives 8'h2A, an input of 0 gives 8'hD5 and an input of -1 gives 8'h55.
- R9: µ-law decoding inverts the code to u. The magnitude is ((u[3:0]·8 + 132) << u[6:4]) - 132, negated when u[7] is 1. Codes 8'hFF and 8'h7F both give 0, 8'h80 gives 32124 and 8'h00 gives -32124.
- R10: A-law decoding XORs the code with 8'h55 to get a. The value is t = a[3:0]·16 + 8 for segment 0. For segment s >= 1 it is t = (a[3:0]·16 + 264) << (s-1). The result is positive when a[7] is 1 and negative otherwise. So 8'hD5 gives 8, 8'h55 gives -8, 8'hAA gives 32256 and 8'h2A gives -32256.
- R11: `alaw_sel_i` = 0 selects µ-law and 1 selects A-law. The law is sampled in the same cycle as the valid input, so it can change on every transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alaw_sel_i | input | 1 | Law select: 0 µ-law, 1 A-law |
| enc_valid_i | input | 1 | Encoder input valid |
| enc_lin_i | input | LIN_W | Linear sample to encode, two's complement |
| enc_valid_o | output | 1 | Encoder output valid |
| enc_code_o | output | 8 | Companded code |
| dec_valid_i | input | 1 | Decoder input valid |
| dec_code_i | input | 8 | Companded code to decode |
| dec_valid_o | output | 1 | Decoder output valid |
| dec_lin_o | output | LIN_W | Reconstructed linear sample |

## Verification
The bench builds the block with the default `LIN_W` of 16. At that width, the 16-bit decoder scale maps one-to-one onto the port, and the full signed input range exercises the µ-law clamp region above 32636. Every one of the 256 codes is decoded under both laws. Random samples, weighted toward small magnitudes so that the low segments and both zero codes occur, are encoded while the law select toggles from transfer to transfer.

// File: rtl/g711_pkg.sv
package g711_pkg;
  typedef enum logic {LAW_MU = 1'b0, LAW_A = 1'b1} law_e;

  typedef struct packed {
    logic       sgn;
    logic [2:0] seg;
    logic [3:0] step;
  } pcm_fields_t;

  localparam int unsigned MU_CLIP      = 8159;
  localparam int unsigned MU_BIAS      = 33;
  localparam int unsigned MU_DEC_OFS   = 132;
  localparam int unsigned A_SEG0_OFS   = 8;
  localparam int unsigned A_SEGN_OFS   = 264;
  localparam logic [7:0]  A_EVEN_MASK  = 8'h55;
endpackage

// File: rtl/g711_msb_find.sv
module g711_msb_find #(
  parameter int W = 14,
  localparam int POS_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic [POS_W-1:0] pos_o,
  output logic             found_o
);
  always_comb begin
    pos_o   = '0;
    found_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        pos_o   = POS_W'(i);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/g711_encode.sv
module g711_encode
  import g711_pkg::*;
#(
  parameter int LIN_W = 16
) (
  input  law_e             law_i,
  input  logic [LIN_W-1:0] lin_i,
  output logic [7:0]       code_o
);
  localparam int MU_W = 14;
  localparam int A_W  = 13;

  logic unused_lsbs;
  assign unused_lsbs = ^lin_i[LIN_W-MU_W-1:0];

  // mu-law path on the top 14 bits
  logic signed [MU_W-1:0] mu_s;
  logic [MU_W:0]          mu_mag;
  logic [MU_W-1:0]        mu_clip, mu_bias;
  logic [3:0]             mu_pos, mu_seg, mu_step;
  logic                   mu_found;
  logic [7:0]             mu_nat, mu_code;

  assign mu_s    = lin_i[LIN_W-1 -: MU_W];
  assign mu_mag  = mu_s[MU_W-1] ? ((MU_W+1)'(0) - {1'b1, mu_s}) : {1'b0, mu_s};
  assign mu_clip = (mu_mag > (MU_W+1)'(MU_CLIP)) ? MU_W'(MU_CLIP) : mu_mag[MU_W-1:0];
  assign mu_bias = mu_clip + MU_W'(MU_BIAS);

  g711_msb_find #(.W(MU_W)) u_mu_msb (
    .vec_i  (mu_bias),
    .pos_o  (mu_pos),
    .found_o(mu_found)
  );

  assign mu_seg  = mu_found ? (mu_pos - 4'd5) : 4'd0;
  assign mu_step = mu_bias[mu_pos - 4'd4 +: 4];
  // segment 8 means the biased magnitude overflowed: full scale
  assign mu_nat  = mu_seg[3] ? 8'h7F : {1'b0, mu_seg[2:0], mu_step};
  assign mu_code = mu_nat ^ (mu_s[MU_W-1] ? 8'h7F : 8'hFF);

  // A-law path on the top 13 bits
  logic signed [A_W-1:0] a_s;
  logic [A_W-2:0]        a_mag;
  logic [3:0]            a_pos;
  logic                  a_found;
  logic [2:0]            a_seg;
  logic [3:0]            a_step;
  pcm_fields_t           a_nat;

  assign a_s   = lin_i[LIN_W-1 -: A_W];
  assign a_mag = a_s[A_W-1] ? ~a_s[A_W-2:0] : a_s[A_W-2:0];

  g711_msb_find #(.W(A_W-1)) u_a_msb (
    .vec_i  (a_mag),
    .pos_o  (a_pos),
    .found_o(a_found)
  );

  assign a_seg  = (a_found && a_pos >= 4'd5) ? 3'(a_pos - 4'd4) : 3'd0;
  assign a_step = (a_seg < 3'd2) ? a_mag[4:1] : a_mag[a_seg +: 4];
  assign a_nat  = '{sgn: ~a_s[A_W-1], seg: a_seg, step: a_step};

  assign code_o = (law_i == LAW_A) ? (a_nat ^ A_EVEN_MASK) : mu_code;
endmodule

// File: rtl/g711_decode.sv
module g711_decode
  import g711_pkg::*;
#(
  parameter int LIN_W = 16
) (
  input  law_e             law_i,
  input  logic [7:0]       code_i,
  output logic [LIN_W-1:0] lin_o
);
  pcm_fields_t mu_f, a_f;
  logic [15:0] mu_t, mu_val;
  logic [15:0] a_base, a_t, a_val;
  logic [15:0] lin16;

  assign mu_f   = ~code_i;
  assign mu_t   = ({8'd0, mu_f.step, 4'd0} >> 1) + 16'(MU_DEC_OFS) << mu_f.seg;
  assign mu_val = mu_f.sgn ? (16'(MU_DEC_OFS) - mu_t) : (mu_t - 16'(MU_DEC_OFS));

  assign a_f    = code_i ^ A_EVEN_MASK;
  assign a_base = {8'd0, a_f.step, 4'd0} +
                  ((a_f.seg == 3'd0) ? 16'(A_SEG0_OFS) : 16'(A_SEGN_OFS));
  assign a_t    = (a_f.seg > 3'd1) ? (a_base << (a_f.seg - 3'd1)) : a_base;
  assign a_val  = a_f.sgn ? a_t : (16'd0 - a_t);

  assign lin16  = (law_i == LAW_A) ? a_val : mu_val;

  generate
    if (LIN_W == 16) begin : g_exact
      assign lin_o = lin16;
    end else begin : g_wide
      assign lin_o = {lin16, {(LIN_W-16){1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/g711_compander.sv
module g711_compander
  import g711_pkg::*;
#(
  parameter int LIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alaw_sel_i,
  input  logic             enc_valid_i,
  input  logic [LIN_W-1:0] enc_lin_i,
  output logic             enc_valid_o,
  output logic [7:0]       enc_code_o,
  input  logic             dec_valid_i,
  input  logic [7:0]       dec_code_i,
  output logic             dec_valid_o,
  output logic [LIN_W-1:0] dec_lin_o
);
  law_e             law;
  logic [7:0]       enc_code_d;
  logic [LIN_W-1:0] dec_lin_d;

  assign law = law_e'(alaw_sel_i);

  g711_encode #(.LIN_W(LIN_W)) u_enc (
    .law_i (law),
    .lin_i (enc_lin_i),
    .code_o(enc_code_d)
  );

  g711_decode #(.LIN_W(LIN_W)) u_dec (
    .law_i (law),
    .code_i(dec_code_i),
    .lin_o (dec_lin_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_valid_o <= 1'b0;
      enc_code_o  <= '0;
      dec_valid_o <= 1'b0;
      dec_lin_o   <= '0;
    end else begin
      enc_valid_o <= enc_valid_i;
      dec_valid_o <= dec_valid_i;
      if (enc_valid_i) enc_code_o <= enc_code_d;
      if (dec_valid_i) dec_lin_o  <= dec_lin_d;
    end
  end
endmodule

// File: rtl/g711_compander_chk.sv
module g711_compander_chk #(
  parameter int LIN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             alaw_sel_i,
  input logic             enc_valid_i,
  input logic [LIN_W-1:0] enc_lin_i,
  input logic             enc_valid_o,
  input logic [7:0]       enc_code_o,
  input logic             dec_valid_i,
  input logic [7:0]       dec_code_i,
  input logic             dec_valid_o,
  input logic [LIN_W-1:0] dec_lin_o
);
  assert_enc_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_i |=> enc_valid_o);
  assert_enc_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_valid_i |=> !enc_valid_o);
  assert_dec_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i |=> dec_valid_o);
  assert_dec_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> !dec_valid_o);

  assert_enc_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_valid_i |=> $stable(enc_code_o));
  assert_dec_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> $stable(dec_lin_o));

  assert_enc_sign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_i |=> (enc_code_o[7] == !$past(enc_lin_i[LIN_W-1])));

  assert_mu_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && !alaw_sel_i && (dec_code_i[6:0] == 7'h7F)) |=> (dec_lin_o == '0));

  assert_a_sign_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && alaw_sel_i) |=> ($signed(dec_lin_o) > 0) == $past(dec_code_i[7]));
endmodule

bind g711_compander g711_compander_chk #(.LIN_W(LIN_W)) u_chk (.*);

// File: tb/sim_g711_compander.sv
`timescale 1ns/1ps
module sim_g711_compander;
  localparam int LIN_W = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             alaw_sel_i = 1'b0;
  logic             enc_valid_i = 1'b0;
  logic [LIN_W-1:0] enc_lin_i = '0;
  logic             enc_valid_o;
  logic [7:0]       enc_code_o;
  logic             dec_valid_i = 1'b0;
  logic [7:0]       dec_code_i = '0;
  logic             dec_valid_o;
  logic [LIN_W-1:0] dec_lin_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0]  exp_code = '0;
  logic [15:0] exp_lin = '0;

  always #2.5 clk = ~clk;

  g711_compander #(.LIN_W(LIN_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .alaw_sel_i(alaw_sel_i),
    .enc_valid_i(enc_valid_i), .enc_lin_i(enc_lin_i),
    .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
    .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
    .dec_valid_o(dec_valid_o), .dec_lin_o(dec_lin_o)
  );

  function automatic logic [7:0] ref_enc(input logic law, input logic [15:0] x);
    int v, seg;
    logic [7:0] m;
    v = int'($signed(x));
    seg = 0;
    if (!law) begin
      v = v >>> 2;
      if (v < 0) begin v = -v; m = 8'h7F; end else m = 8'hFF;
      if (v > 8159) v = 8159;
      v = v + 33;
      while (seg < 8 && v >= (64 << seg)) seg++;
      if (seg == 8) return 8'h7F ^ m;
      return 8'((seg << 4) | ((v >> (seg + 1)) & 15)) ^ m;
    end
    v = v >>> 3;
    if (v >= 0) m = 8'hD5; else begin m = 8'h55; v = -v - 1; end
    while (seg < 8 && v >= (32 << seg)) seg++;
    if (seg == 8) return 8'h7F ^ m;
    if (seg < 2) return 8'((seg << 4) | ((v >> 1) & 15)) ^ m;
    return 8'((seg << 4) | ((v >> seg) & 15)) ^ m;
  endfunction

  function automatic logic [15:0] ref_dec(input logic law, input logic [7:0] c);
    int u, t, s;
    if (!law) begin
      u = int'(~c) & 255;
      t = ((u & 15) << 3) + 132;
      t = t << ((u >> 4) & 7);
      return 16'(((u & 128) != 0) ? (132 - t) : (t - 132));
    end
    u = int'(c ^ 8'h55) & 255;
    s = (u >> 4) & 7;
    t = (u & 15) << 4;
    t = t + ((s == 0) ? 8 : 264);
    if (s > 1) t = t << (s - 1);
    return 16'(((u & 128) != 0) ? t : -t);
  endfunction

  task automatic check_out(input string tag);
    logic ev, dv;
    ev = enc_valid_i;
    dv = dec_valid_i;
    @(posedge clk);
    #1;
    n_run += 4;
    if (enc_valid_o !== ev) begin
      n_fail++;
      $display("FAIL R2 %s enc_valid_o act=%b exp=%b", tag, enc_valid_o, ev);
    end
    if (dec_valid_o !== dv) begin
      n_fail++;
      $display("FAIL R2 %s dec_valid_o act=%b exp=%b", tag, dec_valid_o, dv);
    end
    if (enc_code_o !== exp_code) begin
      n_fail++;
      $display("FAIL %s enc_code_o act=%h exp=%h", tag, enc_code_o, exp_code);
    end
    if (dec_lin_o !== exp_lin) begin
      n_fail++;
      $display("FAIL %s dec_lin_o act=%0d exp=%0d", tag,
               $signed(dec_lin_o), $signed(exp_lin));
    end
    @(negedge clk);
  endtask

  task automatic step(input logic law, input logic ev, input logic [15:0] lin,
                      input logic dv, input logic [7:0] code, input string tag);
    alaw_sel_i  = law;
    enc_valid_i = ev;
    enc_lin_i   = lin;
    dec_valid_i = dv;
    dec_code_i  = code;
    if (ev) exp_code = ref_enc(law, lin);
    if (dv) exp_lin  = ref_dec(law, code);
    check_out(tag);
  endtask

  task automatic expect_code(input string tag, input logic [7:0] want);
    n_run++;
    if (enc_code_o !== want) begin
      n_fail++;
      $display("FAIL %s enc_code_o act=%h exp=%h", tag, enc_code_o, want);
    end
  endtask

  task automatic expect_lin(input string tag, input int want);
    n_run++;
    if ($signed(dec_lin_o) != want) begin
      n_fail++;
      $display("FAIL %s dec_lin_o act=%0d exp=%0d", tag, $signed(dec_lin_o), want);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_sink;
    logic [31:0] r;
    logic [15:0] lin;
    seed_sink = $urandom(32'd20250611);
    repeat (3) @(negedge clk);
    // R1 reset state during and just after reset
    n_run += 4;
    if (enc_valid_o !== 1'b0 || dec_valid_o !== 1'b0 ||
        enc_code_o !== 8'h00 || dec_lin_o !== '0) begin
      n_fail++;
      $display("FAIL R1 reset act=%b%b %h %h exp=00 00 0000",
               enc_valid_o, dec_valid_o, enc_code_o, dec_lin_o);
    end
    rst_ni = 1'b1;
    check_out("R1");

    // R6 mu-law end points and clamp
    step(1'b0, 1'b1, 16'h7FFF, 1'b1, 8'hFF, "R6 R9"); expect_code("R6", 8'h80); expect_lin("R9", 0);
    step(1'b0, 1'b1, 16'h8000, 1'b1, 8'h7F, "R6 R9"); expect_code("R6", 8'h00); expect_lin("R9", 0);
    step(1'b0, 1'b1, 16'h0000, 1'b1, 8'h80, "R6 R9"); expect_code("R6", 8'hFF); expect_lin("R9", 32124);
    step(1'b0, 1'b1, 16'd32640, 1'b1, 8'h00, "R6 R9"); expect_code("R6", 8'h80); expect_lin("R9", -32124);
    // R8 A-law end points, R10 decode end points
    step(1'b1, 1'b1, 16'h7FFF, 1'b1, 8'hD5, "R8 R10"); expect_code("R8", 8'hAA); expect_lin("R10", 8);
    step(1'b1, 1'b1, 16'h8000, 1'b1, 8'h55, "R8 R10"); expect_code("R8", 8'h2A); expect_lin("R10", -8);
    step(1'b1, 1'b1, 16'h0000, 1'b1, 8'hAA, "R8 R10"); expect_code("R8", 8'hD5); expect_lin("R10", 32256);
    step(1'b1, 1'b1, 16'hFFFF, 1'b1, 8'h2A, "R8 R10"); expect_code("R8", 8'h55); expect_lin("R10", -32256);
    // R11 same code under each law on consecutive transfers
    step(1'b0, 1'b1, 16'h0100, 1'b1, 8'hD5, "R11");
    step(1'b1, 1'b1, 16'h0100, 1'b1, 8'hD5, "R11"); expect_lin("R11", 8);
    // R3 inputs change with valid low: outputs hold
    step(1'b0, 1'b0, 16'h1234, 1'b0, 8'h00, "R3"); expect_code("R3", ref_enc(1'b1, 16'h0100));
    step(1'b1, 1'b0, 16'h8000, 1'b0, 8'h80, "R3"); expect_lin("R3", 8);

    // exhaustive decode sweep, both laws (R9, R10)
    for (int law = 0; law < 2; law++) begin
      for (int c = 0; c < 256; c++) begin
        step(law[0], 1'b0, 16'h0000, 1'b1, 8'(c), (law == 0) ? "R9" : "R10");
      end
    end

    // random mix (R2 R3 R4 R5 R7 R11)
    for (int i = 0; i < 3000; i++) begin
      r = $urandom;
      if (r[1:0] == 2'b00) lin = 16'($urandom_range(0, 1023)) - 16'd512;
      else lin = 16'($urandom);
      step(r[2], (r[5:3] != 3'd0), lin, (r[8:6] != 3'd0), 8'($urandom),
           r[2] ? "R7 R10 R4" : "R5 R9 R4");
      if (enc_valid_o) begin
        n_run++;
        if (enc_code_o[7] !== ~lin[15]) begin
          n_fail++;
          $display("FAIL R4 sign act=%b exp=%b", enc_code_o[7], ~lin[15]);
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule